// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a memory-mapped master for the IEEE 802.3 Clause 45 management interface. A host reaches external PHYs through two 32-bit registers. The command word sits at byte offset 0x0. The status word sits at byte offset 0x4. Each host write to the command word that carries a trigger bit launches one 64-bit frame on the serial pair: a clock output MDC, and a data line split into a driven value, an output enable and a sampled input.

A complete PHY register access takes two frames. The first is an address frame that loads the register address into the PHY. The second is a write, read or post-read-increment frame that moves the data. Between commands the host writes an all-zero word and polls the busy flag. Once a read frame has finished, the status word holds a valid flag and the 16 bits returned by the PHY. MDC comes from the system clock through a parameterized divider. Its default divides a 100 MHz clock down to 2.5 MHz.

Top module: `c45_mdio_master`

## Requirements
- R1: Reading offset 0x0 returns the last accepted command word. Reading 0x4 returns {valid[31], busy[30], zeros in 29:16, read data in 15:0}. Every other offset reads zero. All fields are zero after reset.
- R2: A command write with bit 31 or bit 30 set, made while not busy, starts a frame. Busy reads 1 from the next cycle and stays 1 until the frame's last MDC falling edge. It then reads 0.
- R3: A command write with both bits 31 and 30 clear, including the all-zero word, starts no frame. MDC stays low and busy stays 0. The word is still stored for readback.
- R4: Each frame is sent MSB first, in this order: 32 ones, start 00, the opcode from bits 27:26, the port address from bits 25:21, the device address from bits 20:16, turnaround 10, and the 16 bits from 15:0. Opcode values 0, 1, 3 and 2 (address, write, read, post-read-increment) are sent as given.
- R5: A read-triggered frame (bit 30 set, bit 31 clear) drives bit positions 0 to 45 and releases the line (enable low) for the turnaround and data, positions 46 to 63. Other frames drive all 64 positions. The enable is low whenever the block is idle.
- R6: The driven data bit changes only on MDC falling edges, or before the first rising edge of a frame. Input data is sampled on MDC rising edges.
- R7: MDC idles low. While a frame runs, MDC has a period of 2*MDC_HALF_DIV clock cycles. Each frame has exactly 64 rising edges.
- R8: When a read-triggered frame ends, valid becomes 1 and bits 15:0 hold the 16 bits sampled during data positions 48 to 63, first bit in bit 15. Other frames leave bits 15:0 unchanged.
- R9: Accepting a triggered command clears valid.
- R10: A command write made while busy is ignored. The running frame, the stored command word and the frame count are all unchanged.
- R11: When bits 31 and 30 are both set, the frame is treated as a write-triggered frame. It drives all positions and does not set valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Driven management data bit |
| mdio_oe | output | 1 | Drive enable for the management data line |
| mdio_i | input | 1 | Sampled management data line |

## Verification
Some rules are checked on every cycle by the assertions. A high MDC always means busy. The enable is low whenever the block is idle, and stays low through the data phase of a read frame. The driven bit only moves on a falling MDC edge. Writes without a trigger bit never raise busy. Writes made while busy leave the stored word untouched. Accepting a command clears valid. Other behaviour needs the bench's PHY model, which gathers each whole frame and compares it bit for bit with the expected frame. This covers the frame layout, the 64-edge MDC count and period, the data returned by the PHY and where it lands, and the handling of both trigger bits together.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam int WR_GO_BIT  = 31;
  localparam int RD_GO_BIT  = 30;

  // Serial image of one frame, first bit in the MSB.
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [31:0] cmd);
    return {{PRE_BITS{1'b1}}, 2'b00, cmd[27:26], cmd[25:21], cmd[20:16], 2'b10, cmd[15:0]};
  endfunction

  // True when a frame position is left to the PHY.
  function automatic logic released_bit(input logic rd_frame, input logic [IDX_W-1:0] idx);
    return rd_frame && (int'(idx) >= TA_POS);
  endfunction

  function automatic logic is_trigger(input logic [31:0] cmd);
    return cmd[WR_GO_BIT] | cmd[RD_GO_BIT];
  endfunction

  function automatic logic is_read_trigger(input logic [31:0] cmd);
    return cmd[RD_GO_BIT] & ~cmd[WR_GO_BIT];
  endfunction

  function automatic logic [31:0] pack_status(input logic valid, input logic busy,
                                              input logic [15:0] data);
    return {valid, busy, 14'd0, data};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic mdc_rise,
  output logic mdc_fall
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] WRAP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap_hit;

  assign wrap_hit = run && (cnt == WRAP);
  assign mdc_rise = wrap_hit && !mdc;
  assign mdc_fall = wrap_hit && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == WRAP) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R7: a rising edge is followed by a high MDC
  assert_rise_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_rise |=> mdc);

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_c45_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] start_frame,
  input  logic                  start_rd,
  input  logic                  mdc_rise,
  input  logic                  mdc_fall,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  frame_done,
  output logic                  frame_rd,
  output logic [15:0]           cap_data,
  output logic                  mdio_o,
  output logic                  mdio_oe
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sreg;
  logic [IDX_W-1:0]      bitcnt;
  logic [IDX_W-1:0]      nxt_idx;
  logic                  in_data;

  assign nxt_idx    = bitcnt + IDX_W'(1);
  assign in_data    = int'(bitcnt) >= DATA_POS;
  assign frame_done = active && mdc_fall && (bitcnt == LAST);
  assign mdio_o     = sreg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sreg     <= '1;
      bitcnt   <= '0;
      frame_rd <= 1'b0;
      cap_data <= '0;
      mdio_oe  <= 1'b0;
    end else if (start && !active) begin
      active   <= 1'b1;
      sreg     <= start_frame;
      bitcnt   <= '0;
      frame_rd <= start_rd;
      mdio_oe  <= 1'b1;
    end else if (active) begin
      if (mdc_rise && frame_rd && in_data) begin
        cap_data <= {cap_data[14:0], mdio_i};
      end
      if (mdc_fall) begin
        if (bitcnt == LAST) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          bitcnt  <= nxt_idx;
          sreg    <= {sreg[FRAME_BITS-2:0], 1'b1};
          mdio_oe <= !released_bit(frame_rd, nxt_idx);
        end
      end
    end
  end

  // R6: the driven bit holds between falling MDC edges
  assert_hold_between_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mdc_fall) |=> $stable(mdio_o));

  // R5: the PHY owns the line during the data phase of a read frame
  assert_release_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && frame_rd && in_data) |-> !mdio_oe);

  // R7: a frame never ends before its last position
  assert_no_early_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mdc_fall && bitcnt != LAST) |=> active);

  // R7: the clock divider never reports both edges at once
  assert_edges_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mdc_rise && mdc_fall));

endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_c45_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [AW-1:0]         reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  frame_done,
  input  logic                  frame_rd,
  input  logic [15:0]           cap_data,
  output logic                  start,
  output logic [FRAME_BITS-1:0] start_frame,
  output logic                  start_rd,
  output logic                  busy
);

  localparam logic [AW-1:0] CMD_OFS  = AW'(0);
  localparam logic [AW-1:0] STAT_OFS = AW'(4);

  logic [31:0] cmd_q;
  logic [15:0] rdata_q;
  logic        valid_q;
  logic        wr_cmd;
  logic        accept;

  assign wr_cmd      = reg_wr && (reg_addr == CMD_OFS);
  assign accept      = wr_cmd && !busy;
  assign start       = accept && is_trigger(reg_wdata);
  assign start_rd    = is_read_trigger(reg_wdata);
  assign start_frame = build_frame(reg_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      rdata_q <= '0;
      valid_q <= 1'b0;
      busy    <= 1'b0;
    end else begin
      if (accept) cmd_q <= reg_wdata;
      if (start) begin
        busy    <= 1'b1;
        valid_q <= 1'b0;
      end else if (frame_done) begin
        busy <= 1'b0;
        if (frame_rd) begin
          valid_q <= 1'b1;
          rdata_q <= cap_data;
        end
      end
    end
  end

  always_comb begin
    if (reg_addr == CMD_OFS)       reg_rdata = cmd_q;
    else if (reg_addr == STAT_OFS) reg_rdata = pack_status(valid_q, busy, rdata_q);
    else                           reg_rdata = '0;
  end

  // R3: a word without a trigger bit never makes the block busy
  assert_no_trigger_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !busy && !reg_wdata[WR_GO_BIT] && !reg_wdata[RD_GO_BIT]) |=> !busy);

  // R10: writes while busy leave the stored command alone
  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy) |=> $stable(cmd_q));

  // R9: an accepted command clears valid and raises busy
  assert_valid_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!valid_q && busy));

endmodule

// File: rtl/c45_mdio_master.sv
module c45_mdio_master
  import mdio_c45_pkg::*;
#(
  parameter int AW           = 8,
  parameter int MDC_HALF_DIV = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);

  logic                  start;
  logic [FRAME_BITS-1:0] start_frame;
  logic                  start_rd;
  logic                  busy;
  logic                  active;
  logic                  frame_done;
  logic                  frame_rd;
  logic [15:0]           cap_data;
  logic                  mdc_rise;
  logic                  mdc_fall;

  mdio_csr #(.AW(AW)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .frame_done (frame_done),
    .frame_rd   (frame_rd),
    .cap_data   (cap_data),
    .start      (start),
    .start_frame(start_frame),
    .start_rd   (start_rd),
    .busy       (busy)
  );

  mdio_frame_eng u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_frame(start_frame),
    .start_rd   (start_rd),
    .mdc_rise   (mdc_rise),
    .mdc_fall   (mdc_fall),
    .mdio_i     (mdio_i),
    .active     (active),
    .frame_done (frame_done),
    .frame_rd   (frame_rd),
    .cap_data   (cap_data),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );

  mdio_mdc_gen #(.HALF_DIV(MDC_HALF_DIV)) u_mdc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (active),
    .mdc     (mdc),
    .mdc_rise(mdc_rise),
    .mdc_fall(mdc_fall)
  );

  // R2: MDC only runs while the status reports busy
  assert_mdc_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> busy);

  // R5: the line is released whenever the block is idle
  assert_idle_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R2: busy and the engine's frame activity move together
  assert_busy_tracks_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

endmodule

// File: tb/test_c45_mdio_master.sv
`timescale 1ns/1ps
module test_c45_mdio_master;

  localparam int HALF = 2;
  localparam int AW   = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          mdc;
  logic          mdio_o;
  logic          mdio_oe;
  logic          mdio_i = 1'b1;

  always #5 clk = ~clk;

  c45_mdio_master #(.AW(AW), .MDC_HALF_DIV(HALF)) i_c45_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- PHY model ----------------
  int          rcount = 0;
  int          frames = 0;
  int          period_bad = 0;
  int          edge_bad = 0;
  time         last_rise = 0;
  logic [63:0] cap_o = '0, cap_oe = '0, last_o = '0, last_oe = '0;
  logic [15:0] phy_resp = '0;

  always @(posedge mdc) begin
    if (rcount > 0 && ($time - last_rise) != 2 * HALF * 10) period_bad++;
    last_rise = $time;
    cap_o  = {cap_o[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    rcount++;
    if (rcount == 64) begin
      last_o  = cap_o;
      last_oe = cap_oe;
      frames++;
      rcount = 0;
    end
  end

  always @(negedge mdc) begin
    if (rcount == 47)                      mdio_i <= 1'b0;
    else if (rcount >= 48 && rcount < 64)  mdio_i <= phy_resp[63 - rcount];
    else                                   mdio_i <= 1'b1;
  end

  // R6 monitor: the driven bit moves only on an MDC fall or before a frame's first rise
  logic prev_o = 1'b1, prev_mdc = 1'b0;
  always @(negedge clk) begin
    if (rst_n && mdio_o !== prev_o && !(prev_mdc && !mdc) && rcount != 0) edge_bad++;
    prev_o   = mdio_o;
    prev_mdc = mdc;
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- expected values ----------------
  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    return {32'hFFFF_FFFF, 2'b00, w[27:26], w[25:21], w[20:16], 2'b10, w[15:0]};
  endfunction

  function automatic logic [63:0] exp_oe(input bit rdf);
    return rdf ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
  endfunction

  function automatic logic [31:0] exp_status(input bit v, input bit b, input logic [15:0] d);
    return {v, b, 14'd0, d};
  endfunction

  logic        model_valid = 1'b0;
  logic [15:0] model_data  = '0;

  task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic do_cmd(input logic [31:0] w, input logic [15:0] resp, input logic [31:0] intrude);
    logic [31:0] s;
    int f0;
    int n;
    bit rdf;
    f0  = frames;
    rdf = w[30] && !w[31];
    phy_resp = resp;
    reg_write(8'h0, w);
    reg_read(8'h4, s);
    check("R2 busy after accept", {63'd0, s[30]}, 64'd1);
    check("R9 valid cleared on accept", {63'd0, s[31]}, 64'd0);
    reg_read(8'h0, s);
    check("R1 command readback", {32'd0, s}, {32'd0, w});
    if (intrude != 32'd0) begin
      repeat (20) @(negedge clk);
      reg_write(8'h0, intrude);
      reg_read(8'h0, s);
      check("R10 stored word kept while busy", {32'd0, s}, {32'd0, w});
    end
    n = 0;
    do begin
      @(negedge clk);
      reg_read(8'h4, s);
      n++;
    end while (s[30] && n < 5000);
    check("R2 busy clears only after the frame", frames - f0, 1);
    check("R7 MDC low after frame", {63'd0, mdc}, 64'd0);
    if (rdf) check("R4 frame bits (read)", last_o[63:18], exp_frame(w) >> 18);
    else     check("R4 frame bits", last_o, exp_frame(w));
    if (w[31] && w[30]) check("R11 both triggers drive all bits", last_oe, exp_oe(1'b0));
    else                check("R5 enable pattern", last_oe, exp_oe(rdf));
    if (rdf) begin
      model_valid = 1'b1;
      model_data  = resp;
    end else begin
      model_valid = 1'b0;
    end
    check("R8 status after frame", {32'd0, s}, {32'd0, exp_status(model_valid, 1'b0, model_data)});
    reg_write(8'h0, 32'h0);
    repeat (12) @(negedge clk);
    reg_read(8'h4, s);
    check("R3 zero write starts nothing", {frames - f0, 31'd0, s[30]}, {32'd1, 32'd0});
    check("R5 idle enable low", {62'd0, mdio_oe, mdc}, 64'd0);
  endtask

  initial begin
    logic [31:0] s;
    int          f0;
    logic [31:0] w;
    int          seed;
    seed      = $urandom(20240611);
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    reg_read(8'h0, s); check("R1 reset command word", {32'd0, s}, 64'd0);
    reg_read(8'h4, s); check("R1 reset status word", {32'd0, s}, 64'd0);
    reg_read(8'h8, s); check("R1 unmapped offset", {32'd0, s}, 64'd0);
    check("R7 reset MDC and enable low", {62'd0, mdc, mdio_oe}, 64'd0);

    // Register write: address frame, then write frame (opcodes 0 and 1)
    do_cmd(32'h8000_0000 | (32'd0 << 26) | (32'd5 << 21) | (32'd1 << 16) | 32'h1234, 16'h0, 32'h0);
    do_cmd(32'h8000_0000 | (32'd1 << 26) | (32'd5 << 21) | (32'd1 << 16) | 32'hBEEF, 16'h0, 32'h0);
    // Register read: address frame, then read frame (opcode 3, bit 30)
    do_cmd(32'h8000_0000 | (32'd0 << 26) | (32'd31 << 21) | (32'd31 << 16) | 32'hFFFF, 16'h0, 32'h0);
    do_cmd(32'h4000_0000 | (32'd3 << 26) | (32'd31 << 21) | (32'd31 << 16), 16'hA5C3, 32'h0);
    // Post-read-increment (opcode 2) with all-ones and all-zeros data
    do_cmd(32'h4000_0000 | (32'd2 << 26) | (32'd0 << 21) | (32'd7 << 16), 16'hFFFF, 32'h0);
    do_cmd(32'h4000_0000 | (32'd2 << 26) | (32'd9 << 21) | (32'd3 << 16), 16'h0000, 32'h0);
    // Write after read: valid drops, data held (R8)
    do_cmd(32'h8000_0000 | (32'd1 << 26) | (32'd2 << 21) | (32'd2 << 16) | 32'h0F0F, 16'h0, 32'h0);
    // Both triggers (R11)
    do_cmd(32'hC000_0000 | (32'd3 << 26) | (32'd4 << 21) | (32'd8 << 16) | 32'h5A5A, 16'h1111, 32'h0);
    // Write while busy ignored (R10)
    do_cmd(32'h4000_0000 | (32'd3 << 26) | (32'd6 << 21) | (32'd6 << 16), 16'h8001, 32'h8400_ABCD);

    // R3: untriggered nonzero word stored but starts nothing
    f0 = frames;
    reg_write(8'h0, 32'h0FFF_FFFF);
    repeat (30) @(negedge clk);
    reg_read(8'h0, s);
    check("R3 untriggered word stored", {32'd0, s}, {32'd0, 32'h0FFF_FFFF});
    reg_read(8'h4, s);
    check("R3 untriggered word starts no frame", {frames - f0, 31'd0, s[30]}, 64'd0);
    check("R3 MDC stays low", {63'd0, mdc}, 64'd0);
    reg_write(8'h0, 32'h0);

    // Random commands
    for (int i = 0; i < 24; i++) begin
      int kind;
      w    = $urandom;
      kind = int'($urandom % 3);
      w[31:30] = (kind == 0) ? 2'b10 : (kind == 1) ? 2'b01 : 2'b11;
      do_cmd(w, 16'($urandom), 32'h0);
    end

    check("R6 driven bit moved off a falling edge", edge_bad, 0);
    check("R7 MDC period", period_bad, 0);
    check("R7 no partial frame left", rcount, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule